// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A 32-pin general-purpose I/O port that software controls through a small word-addressed register bus. Outputs are changed by writing a bit mask to a set register or a clear register, so software never has to read a register, modify it and write it back. Either write also turns the masked pins into outputs. A separate register returns masked pins to input mode.

Pin levels pass through a two-flop synchronizer and can be read from a pin-state register. After reset, pin inputs are held off from that register until software writes the input-arm register once. The value written there does not matter. The read data path is combinational from the decoded address, and register writes take effect on the rising clock edge where the write strobe is high.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset every output latch bit is 0, every pin is an input (output enable 0), and the pin-state register (word address 3) reads all zeros.
- R2: A write to word address 0 (output-set) drives every pin whose mask bit is 1 to high and leaves the latch bits of all other pins unchanged.
- R3: A write to word address 1 (output-clear) drives every pin whose mask bit is 1 to low and leaves the latch bits of all other pins unchanged.
- R4: A write to the set or clear register also makes every masked pin an output (output enable 1). The direction of unmasked pins does not change.
- R5: A write to word address 2 (tristate-clear) makes every masked pin an input. It leaves the direction of other pins and all output latch bits unchanged.
- R6: Once the inputs are armed, a pin level change that is applied before a rising edge shows in the pin-state read after the second rising edge, not after the first.
- R7: Until the inputs are armed, the pin-state register reads zero whatever the pin levels are.
- R8: Any write to word address 4 (input-arm) arms the inputs, whatever the data value, including zero. The inputs stay armed until the next reset.
- R9: Reads of addresses 0 and 1 return the output latch vector. A read of address 2 returns the output-enable vector. Reads of addresses 4 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register access |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_out | output | 32 | Output latch value per pin |
| pin_oe | output | 32 | Output enable per pin (1 = driving) |
| pin_in | input | 32 | Pin levels from the pads (asynchronous) |

## Verification
The set, clear and tristate-clear writes are run in a sequence of masks. The sequence has a low byte, a high nibble, all ones, an alternating pattern and an empty mask. Each step is checked on both the pins and the readback, which shows that a mask acts only on its own bits and that direction and latch are kept apart. The input path is tried with every pin high before the inputs are armed, which separates gating from synchronization. It is then given a new pattern after arming and sampled after one edge and after two edges to pin down the synchronizer depth. Arming with a zero data word, and a second reset, show that only the write event matters and that reset clears the armed state.

// File: rtl/gpio_scp_pkg.sv
package gpio_scp_pkg;
  localparam int unsigned PORT_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_SET   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LEVEL = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARM   = 3'd4;
endpackage

// File: rtl/gpio_scp_outregs.sv
module gpio_scp_outregs #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic         tri_stb,
  input  logic [N-1:0] mask,
  output logic [N-1:0] out_q,
  output logic [N-1:0] oe_q
);
  // latch arithmetic kept in functions so each write kind is one line
  function automatic logic [N-1:0] f_set(input logic [N-1:0] cur, input logic [N-1:0] m);
    return cur | m;
  endfunction
  function automatic logic [N-1:0] f_clr(input logic [N-1:0] cur, input logic [N-1:0] m);
    return cur & ~m;
  endfunction

  logic [N-1:0] out_nx, oe_nx;

  always_comb begin
    out_nx = out_q;
    oe_nx  = oe_q;
    if (set_stb) begin
      out_nx = f_set(out_q, mask);
      oe_nx  = f_set(oe_q, mask);
    end else if (clr_stb) begin
      out_nx = f_clr(out_q, mask);
      oe_nx  = f_set(oe_q, mask);
    end else if (tri_stb) begin
      oe_nx  = f_clr(oe_q, mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_nx;
      oe_q  <= oe_nx;
    end
  end
endmodule

// File: rtl/gpio_scp_sync.sv
module gpio_scp_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [STAGES-1:0][N-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[s] <= '0;
      else if (s == 0) chain[s] <= din;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_scp_ingate.sv
module gpio_scp_ingate #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_stb,
  input  logic [N-1:0] synced,
  output logic         armed,
  output logic [N-1:0] level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (arm_stb) armed <= 1'b1;
  end

  assign level = armed ? synced : '0;
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_scp_pkg::*;
#(
  parameter int unsigned NPINS   = PORT_W,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_we,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic [NPINS-1:0] pin_in
);
  // named internal events, visible to the bound checker
  logic set_stb, clr_stb, tri_stb, arm_stb;
  logic in_armed;
  logic [NPINS-1:0] pin_synced, pin_level;

  assign set_stb = bus_we && (bus_addr == AW'(A_SET));
  assign clr_stb = bus_we && (bus_addr == AW'(A_CLR));
  assign tri_stb = bus_we && (bus_addr == AW'(A_TRI));
  assign arm_stb = bus_we && (bus_addr == AW'(A_ARM));

  gpio_scp_outregs #(.N(NPINS)) u_out (
    .clk(clk), .rst_n(rst_n),
    .set_stb(set_stb), .clr_stb(clr_stb), .tri_stb(tri_stb),
    .mask(bus_wdata), .out_q(pin_out), .oe_q(pin_oe)
  );

  gpio_scp_sync #(.N(NPINS), .STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_synced)
  );

  gpio_scp_ingate #(.N(NPINS)) u_gate (
    .clk(clk), .rst_n(rst_n), .arm_stb(arm_stb),
    .synced(pin_synced), .armed(in_armed), .level(pin_level)
  );

  always_comb begin
    unique case (bus_addr)
      AW'(A_SET), AW'(A_CLR): bus_rdata = pin_out;
      AW'(A_TRI):             bus_rdata = pin_oe;
      AW'(A_LEVEL):           bus_rdata = pin_level;
      default:                bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_scp_chk.sv
module gpio_scp_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0] bus_wdata,
  input logic         bus_we,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] pin_level,
  input logic         in_armed
);
  logic w_set, w_clr, w_tri, w_arm;
  assign w_set = bus_we && (bus_addr == AW'(0));
  assign w_clr = bus_we && (bus_addr == AW'(1));
  assign w_tri = bus_we && (bus_addr == AW'(2));
  assign w_arm = bus_we && (bus_addr == AW'(4));

  a_r2_set_masked: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
              ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  a_r3_clr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> ((pin_out & $past(bus_wdata)) == '0) &&
              ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  a_r4_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (w_set || w_clr) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)) &&
                         ((pin_oe & ~$past(bus_wdata)) == ($past(pin_oe) & ~$past(bus_wdata))));

  a_r5_tri_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    w_tri |=> ((pin_oe & $past(bus_wdata)) == '0) && $stable(pin_out));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !in_armed |-> (pin_level == '0));

  a_r8_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_armed) |-> $past(w_arm));

  a_r8_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_armed |=> in_armed);
endmodule

bind gpio_setclr_port gpio_scp_chk #(.N(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_level(pin_level), .in_armed(in_armed)
);

// File: tb/sim_gpio_setclr_port.sv
`timescale 1ns/1ps
module sim_gpio_setclr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic [31:0] pin_in = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  gpio_setclr_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_in(pin_in)
  );

  // {addr, mask, expected latch, expected output enable}
  localparam int NV = 8;
  localparam logic [98:0] VEC [NV] = '{
    {3'd0, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_00FF},
    {3'd1, 32'h0000_000F, 32'h0000_00F0, 32'h0000_00FF},
    {3'd0, 32'hF000_0000, 32'hF000_00F0, 32'hF000_00FF},
    {3'd2, 32'h0000_00F0, 32'hF000_00F0, 32'hF000_000F},
    {3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {3'd0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hFFFF_FFFF},
    {3'd2, 32'h0F0F_0F0F, 32'hA5A5_A5A5, 32'hF0F0_F0F0},
    {3'd0, 32'h0000_0000, 32'hA5A5_A5A5, 32'hF0F0_F0F0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    pin_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 latch", pin_out, 32'h0);
    check("R1 oe", pin_oe, 32'h0);
    rd(3'd3, r); check("R1 pin-state", r, 32'h0);

    // R2 R3 R4 R5 R9 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][98:96], VEC[i][95:64]);
      check("R2/R3 latch pins", pin_out, VEC[i][63:32]);
      check("R4/R5 direction pins", pin_oe, VEC[i][31:0]);
      rd(3'd0, r); check("R9 set readback", r, VEC[i][63:32]);
      rd(3'd1, r); check("R9 clr readback", r, VEC[i][63:32]);
      rd(3'd2, r); check("R9 tri readback", r, VEC[i][31:0]);
    end
    rd(3'd5, r); check("R9 unmapped read", r, 32'h0);

    // R7 pins high for many cycles but not armed
    repeat (4) @(negedge clk);
    rd(3'd3, r); check("R7 gated before arm", r, 32'h0);

    // R8 arm with zero data
    wr(3'd4, 32'h0);
    rd(3'd3, r); check("R8 armed by zero write", r, 32'hFFFF_FFFF);
    rd(3'd4, r); check("R9 arm reads zero", r, 32'h0);

    // R6 two-edge latency
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(negedge clk);
    rd(3'd3, r); check("R6 after one edge", r, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(3'd3, r); check("R6 after two edges", r, 32'h1234_5678);

    // R8 stays armed across other writes
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd3, r); check("R8 sticky arm", r, 32'h1234_5678);

    // R1 R8 reset clears arm and registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd3, r); check("R8 reset disarms", r, 32'h0);
    check("R1 latch after reset", pin_out, 32'h0);
    check("R1 oe after reset", pin_oe, 32'h0);

    finish_run();
  end
endmodule